// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives the serial clock of a SPI master from the core clock. A configuration word supplies three fields. The first is a 4-bit linear prescale. The second is a 3-bit power-of-two exponent whose bits sit at scattered word positions. The third is a further power-of-two SCLK divider exponent. The resulting divide ratio is the product of the linear value and the two powers of two. The block drives a mode-0 serial clock level, which idles low. It also drives a one-cycle tick that marks every half-period boundary, so a shift engine knows when to launch or sample a bit.

A run input frames each transfer. While run is low the divider sits idle with the clock low, and it keeps tracking the configuration word. The edge that first samples run high starts a frame. That edge freezes the ratio and restarts the phase counter, so the first clock edge of every frame lands at a fixed distance from frame start. Configuration changes made inside a frame wait for the next frame. Working out field values from a wanted baud rate is a software task.

Top module: `sclk_div_gen`

## Requirements
- R1: While rst_ni is low, sclk_o and tick_o are 0, whatever run_i and cfg_i do.
- R2: When run_i was sampled low at the last rising clock edge, sclk_o and tick_o are 0 after that edge.
- R3: The frame ratio is R = P * 2^E * 2^S. P is cfg_i[3:0], with 0 read as 1. E = cfg_i[4] + 2*cfg_i[6] + 4*cfg_i[7]. S = cfg_i[13:11]. Inside a frame, sclk_o is periodic with a period of R core cycles.
- R4: A computed product of 1 is raised to a ratio of 2.
- R5: A word that sets only bit 4 among the exponent bits, with prescale v, gives an even ratio of 2*v (2 to 30).
- R6: Each period of sclk_o starts with floor(R/2) low cycles, followed by ceil(R/2) high cycles. For odd R the high phase is one cycle longer.
- R7: tick_o is high for exactly one cycle before each sclk_o transition inside a frame, and sclk_o changes only at edges where tick_o was high.
- R8: The edge that first samples run_i high after a low sample starts a frame with sclk_o low and the counter at zero. The first rise of sclk_o comes floor(R/2) edges later. Dropping run_i and raising it again restarts this alignment, whatever phase the clock was in.
- R9: cfg_i is captured at the frame-start edge. Changes to cfg_i while run_i stays high have no effect until the next frame.
- R10: Values 5 to 7 in cfg_i[13:11] act as 4, a division by 16.
- R11: cfg_i bits 5, 8, 9, 10, 14 and 15 have no effect on the ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Frame active; a rise restarts the divider |
| cfg_i | input | 16 | Configuration word holding the prescale and exponent fields |
| sclk_o | output | 1 | Serial clock level, idle low |
| tick_o | output | 1 | One-cycle mark before each serial clock transition |

## Verification
The frame-start edge is the rising edge that first samples run_i high. After it, sclk_o is low and the phase counter is zero. The bench counts rising edges from that point: k edges later, sclk_o is high exactly when k mod R is at least floor(R/2), and tick_o is high when k mod R is floor(R/2)-1 or R-1. Every comparison is taken at the falling edge that follows the rising edge being counted. This way both the registered clock level and the tick decoded from the counter have settled. Idle behaviour after run_i drops is due one edge later and is sampled the same way.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  localparam int CFG_W    = 16;
  localparam int PRE_LSB  = 0;
  localparam int PRE_W    = 4;
  localparam int PEXP_N   = 3;
  localparam int SDIV_LSB = 11;
  localparam int SDIV_W   = 3;
  localparam int SDIV_MAX = 4;

  localparam int PEXP_MAX  = (1 << PEXP_N) - 1;
  localparam int EXP_MAX   = PEXP_MAX + SDIV_MAX;
  localparam int EXP_W     = $clog2(EXP_MAX + 1);
  localparam int RATIO_W   = PRE_W + EXP_MAX;
  localparam int MIN_RATIO = 2;

  typedef logic [RATIO_W-1:0] ratio_t;

  // word position of each pre-prescale exponent bit, LSB first
  function automatic int pexp_pos(input int idx);
    case (idx)
      0:       return 4;
      1:       return 6;
      default: return 7;
    endcase
  endfunction

endpackage

// File: rtl/sclk_cfg_decode.sv
module sclk_cfg_decode
  import sclk_div_pkg::*;
#(
  parameter int CW   = CFG_W,
  parameter int PW   = PRE_W,
  parameter int SW   = SDIV_W,
  parameter int SMAX = SDIV_MAX,
  parameter int EW   = EXP_W
) (
  input  logic [CW-1:0] cfg_i,
  output logic [PW-1:0] pre_o,
  output logic [EW-1:0] exp_o
);

  logic [PEXP_N-1:0] pexp;
  logic [PW-1:0]     pre_raw;
  logic [SW-1:0]     sdiv_raw;
  logic [SW-1:0]     sdiv_eff;
  logic              unused_cfg;

  for (genvar g = 0; g < PEXP_N; g++) begin : g_pexp
    assign pexp[g] = cfg_i[pexp_pos(g)];
  end

  assign pre_raw    = cfg_i[PRE_LSB +: PW];
  assign sdiv_raw   = cfg_i[SDIV_LSB +: SW];
  assign unused_cfg = ^cfg_i;

  always_comb begin
    sdiv_eff = (sdiv_raw > SW'(SMAX)) ? SW'(SMAX) : sdiv_raw;
    pre_o    = (pre_raw == '0) ? PW'(1) : pre_raw;
    exp_o    = EW'(pexp) + EW'(sdiv_eff);
  end

endmodule

// File: rtl/sclk_ratio_calc.sv
module sclk_ratio_calc
  import sclk_div_pkg::*;
#(
  parameter int PW   = PRE_W,
  parameter int EW   = EXP_W,
  parameter int RW   = RATIO_W,
  parameter int MINR = MIN_RATIO
) (
  input  logic [PW-1:0] pre_i,
  input  logic [EW-1:0] exp_i,
  output logic [RW-1:0] lo_len_o,
  output logic [RW-1:0] hi_len_o
);

  logic [RW-1:0] prod;
  logic [RW-1:0] ratio;

  assign prod = RW'(pre_i) << exp_i;

  if (MINR > 1) begin : g_clamp
    assign ratio = (prod < RW'(MINR)) ? RW'(MINR) : prod;
  end else begin : g_pass
    assign ratio = prod;
  end

  // high phase takes the odd cycle
  always_comb begin
    lo_len_o = ratio >> 1;
    hi_len_o = ratio - lo_len_o;
  end

endmodule

// File: rtl/sclk_phase_ctr.sv
module sclk_phase_ctr #(
  parameter int CW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] lo_len_i,
  input  logic [CW-1:0] hi_len_i,
  output logic          active_o,
  output logic          sclk_o,
  output logic          tick_o
);

  logic          run_q;
  logic          sclk_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cur_len;

  assign cur_len  = sclk_q ? hi_len_i : lo_len_i;
  assign tick_o   = run_q && (cnt_q == cur_len - CW'(1));
  assign sclk_o   = sclk_q;
  assign active_o = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!run_i || !run_q) begin
      run_q  <= run_i;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tick_o) begin
      sclk_q <= ~sclk_q;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/sclk_div_gen.sv
module sclk_div_gen
  import sclk_div_pkg::*;
#(
  parameter int CFG_WIDTH = CFG_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [CFG_WIDTH-1:0] cfg_i,
  output logic                 sclk_o,
  output logic                 tick_o
);

  localparam int RW = RATIO_W;

  logic [PRE_W-1:0] pre;
  logic [EXP_W-1:0] expn;
  logic [RW-1:0]    lo_len;
  logic [RW-1:0]    hi_len;
  logic [RW-1:0]    lo_q;
  logic [RW-1:0]    hi_q;
  logic             run_act;

  sclk_cfg_decode #(
    .CW(CFG_WIDTH), .PW(PRE_W), .SW(SDIV_W), .SMAX(SDIV_MAX), .EW(EXP_W)
  ) u_decode (
    .cfg_i (cfg_i),
    .pre_o (pre),
    .exp_o (expn)
  );

  sclk_ratio_calc #(
    .PW(PRE_W), .EW(EXP_W), .RW(RW), .MINR(MIN_RATIO)
  ) u_calc (
    .pre_i    (pre),
    .exp_i    (expn),
    .lo_len_o (lo_len),
    .hi_len_o (hi_len)
  );

  // ratio tracks cfg while idle, frozen once a frame is running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= RW'(MIN_RATIO / 2);
      hi_q <= RW'(MIN_RATIO - MIN_RATIO / 2);
    end else if (!run_act) begin
      lo_q <= lo_len;
      hi_q <= hi_len;
    end
  end

  sclk_phase_ctr #(.CW(RW)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .lo_len_i (lo_q),
    .hi_len_i (hi_q),
    .active_o (run_act),
    .sclk_o   (sclk_o),
    .tick_o   (tick_o)
  );

endmodule

// File: rtl/sclk_div_gen_chk.sv
module sclk_div_gen_chk #(
  parameter int RW = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_i,
  input logic          sclk_o,
  input logic          tick_o,
  input logic          run_act,
  input logic [RW-1:0] lo_q,
  input logic [RW-1:0] hi_q
);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!sclk_o && !tick_o)); // R2

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |=> !sclk_o); // R8

  AST_TICK_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && run_i) |=> (sclk_o != $past(sclk_o))); // R7

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_o) |=> $stable(sclk_o)); // R7

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_act && run_i) |=> ($stable(lo_q) && $stable(hi_q))); // R9

  AST_HALF_BALANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_act |-> (lo_q != '0 && hi_q >= lo_q && hi_q <= lo_q + RW'(1))); // R6

endmodule

bind sclk_div_gen sclk_div_gen_chk #(.RW(RW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .sclk_o  (sclk_o),
  .tick_o  (tick_o),
  .run_act (run_act),
  .lo_q    (lo_q),
  .hi_q    (hi_q)
);

// File: tb/sclk_div_gen_bench.sv
module sclk_div_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int NVEC       = 15;

  typedef struct packed {
    logic [15:0] cfg;
    logic [15:0] ratio;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{16'h0001, 16'd2,   4'd4},
    '{16'h0002, 16'd2,   4'd3},
    '{16'h0003, 16'd3,   4'd3},
    '{16'h000F, 16'd15,  4'd3},
    '{16'h0000, 16'd2,   4'd3},
    '{16'h0015, 16'd10,  4'd5},
    '{16'h001F, 16'd30,  4'd5},
    '{16'h0047, 16'd28,  4'd3},
    '{16'h0085, 16'd80,  4'd3},
    '{16'h00D3, 16'd384, 4'd3},
    '{16'h1803, 16'd24,  4'd3},
    '{16'h2003, 16'd48,  4'd3},
    '{16'h3803, 16'd48,  4'd10},
    '{16'hC723, 16'd3,   4'd11},
    '{16'h2009, 16'd144, 4'd3}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [15:0] cfg_i = 16'h0;
  logic        sclk_o;
  logic        tick_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  sclk_div_gen u_sclk_div_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .cfg_i  (cfg_i),
    .sclk_o (sclk_o),
    .tick_o (tick_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  function automatic string req_tag(input int n);
    case (n)
      4:       return "R4";
      5:       return "R5";
      10:      return "R10";
      11:      return "R11";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input logic act, input logic exp_v, input string tag, input string what);
    n_checks++;
    if (act !== exp_v) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, exp_v, cycles);
    end
  endtask

  // called at a negedge right after run_i was set high
  task automatic observe(input int r, input int n, input string tag,
                         input int k_chg, input logic [15:0] cfg_new);
    int lo;
    lo = r / 2;
    for (int k = 0; k < n; k++) begin
      int t;
      @(negedge clk_i);
      t = k % r;
      check(sclk_o, (t >= lo), tag, "sclk_o");
      check(tick_o, (t == lo - 1) || (t == r - 1), "R7", "tick_o");
      if (k == k_chg) cfg_i = cfg_new;
    end
  endtask

  task automatic check_idle(input string tag);
    check(sclk_o, 1'b0, tag, "sclk_o idle");
    check(tick_o, 1'b0, tag, "tick_o idle");
  endtask

  initial begin
    // R1: reset state, even with run_i high
    cfg_i = 16'h0003;
    repeat (2) @(negedge clk_i);
    check_idle("R1");
    run_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check_idle("R1");
    run_i = 1'b0;
    rst_ni = 1'b1;

    // R2: idle with changing cfg
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      cfg_i = 16'h1111 * 16'(i);
      check_idle("R2");
    end

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk_i);
      run_i = 1'b0;
      cfg_i = VECS[v].cfg;
      @(negedge clk_i);
      check_idle("R2");
      run_i = 1'b1;
      observe(int'(VECS[v].ratio), 2 * int'(VECS[v].ratio) + 3,
              req_tag(int'(VECS[v].req)), -1, 16'h0);
      run_i = 1'b0;
      @(negedge clk_i);
      check_idle("R2");
    end

    // R6: odd ratio, high phase is longer
    cfg_i = 16'h0005;
    @(negedge clk_i);
    run_i = 1'b1;
    observe(5, 15, "R6", -1, 16'h0);
    run_i = 1'b0;
    @(negedge clk_i);

    // R9: cfg change mid-frame is ignored, applied on next frame
    cfg_i = 16'h0004;
    @(negedge clk_i);
    run_i = 1'b1;
    observe(4, 14, "R9", 2, 16'h000F);
    run_i = 1'b0;
    @(negedge clk_i);
    check_idle("R2");
    run_i = 1'b1;
    observe(15, 32, "R9", -1, 16'h0);
    run_i = 1'b0;
    @(negedge clk_i);

    // R8: restart from the middle of a high phase realigns
    cfg_i = 16'h0006;
    @(negedge clk_i);
    run_i = 1'b1;
    observe(6, 5, "R8", -1, 16'h0);
    run_i = 1'b0;
    @(negedge clk_i);
    check_idle("R2");
    run_i = 1'b1;
    observe(6, 13, "R8", -1, 16'h0);
    run_i = 1'b0;
    @(negedge clk_i);
    check_idle("R2");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule